// File: doc/BRIEF.md
# Eight-Channel DMA Register Bank with Transfer Sequencer

This block holds the control and status state for eight DMA channels and steps each channel through its device transfers. Software reaches the state over a simple 32-bit register port that writes on a clock edge and reads without delay. Each channel owns a 32-byte window: the channel number sits in address bits [7:5] and the register kind in bits [4:2]. Kind 0 is the mode word, 1 is the control/status word, 2 is the residual byte count and 3 is the transfer address.

A device raises its request line when it wants one transfer. An enabled, idle channel answers with an acknowledge strobe whose length comes from the access-time code in the mode word. When the acknowledge ends, the address moves up and the count moves down by one or two bytes, depending on the width field. A count that reaches zero, or an error pulse from the memory side, raises a sticky flag and turns the channel off. Software clears a flag by writing a one to it. The interrupt line is high while any channel with its interrupt enabled holds a flag.

Top module: `dmab_bank`

## Requirements
- R1: Decode. Address bits [7:5] pick the channel and bits [4:2] pick the kind (0 mode, 1 control, 2 count, 3 address). Kinds 4 to 7, and any address with bits [1:0] not zero, read as zero and ignore writes. A write touches only the addressed register of the addressed channel.
- R2: The mode word keeps bits [5:0] and reads zero above them. Bits [2:0] hold the access-time code, bits [4:3] the width (binary 10 selects 16-bit steps of 2 bytes, any other value selects 8-bit steps of 1 byte) and bit 5 the interrupt enable.
- R3: In the control word, bit 0 is the enable and bit 1 the direction; both are written directly by software. Output dev_dir follows bit 1, where 1 means the transfer writes memory and 0 means it reads memory.
- R4: A request is taken only when the channel is enabled and no acknowledge is running. dev_ack then goes high on the next cycle and stays high for access-time code + 1 cycles. Requests to a disabled channel produce no acknowledge and leave the count as it was.
- R5: On the edge that ends an acknowledge, the address rises by the step and the count falls by the step. The count stops at zero and does not wrap.
- R6: When a finished transfer brings the count to zero, control bit 8 (terminal count) is set and bit 0 (enable) is cleared on the same edge.
- R7: A mem_err pulse sets control bit 9 and an addr_err pulse sets control bit 10. Either pulse clears the enable bit on the same edge.
- R8: Flags 8 to 10 are sticky. Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. A hardware set in the same cycle as a clearing write leaves the flag set.
- R9: Clearing the enable bit while an acknowledge is running lets that acknowledge finish at its full length and update the count and address. No new request is taken after that.
- R10: irq is high exactly while at least one channel has mode bit 5 set and any of its flags 8 to 10 set.
- R11: After reset, every register reads zero and dev_ack and irq are low.
- R12: The count register reads back the current residual count at any moment (24 bits wide, upper bits zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| dev_req | input | 8 | Per-channel device transfer request |
| dev_ack | output | 8 | Per-channel transfer acknowledge |
| dev_dir | output | 8 | Per-channel direction, 1 = write to memory |
| mem_err | input | 8 | Per-channel memory error pulse |
| addr_err | input | 8 | Per-channel address error pulse |
| irq | output | 1 | Combined interrupt request |

## Verification
Register writes take effect on the edge that samples reg_we. Reads are combinational, so the bench checks the read value half a cycle after the write. A request sampled on an edge raises dev_ack just after that edge. The bench counts acknowledge cycles at each falling edge over a fixed window and compares the total with the access-time code plus one. Count, address, flags and enable change on the edge that ends the acknowledge, or on the edge that samples an error pulse. Every such check reads the register on the falling edge after that point, never on the edge itself.

// File: rtl/dmab_pkg.sv
package dmab_pkg;

  localparam int REG_W = 32;

  // register kinds inside a channel window
  typedef enum logic [2:0] {
    SEL_MODE  = 3'd0,
    SEL_CTRL  = 3'd1,
    SEL_COUNT = 3'd2,
    SEL_XADDR = 3'd3,
    SEL_RSV4  = 3'd4,
    SEL_RSV5  = 3'd5,
    SEL_RSV6  = 3'd6,
    SEL_RSV7  = 3'd7
  } reg_sel_e;

  // control word bit positions
  localparam int CTL_EN   = 0;
  localparam int CTL_DIR  = 1;
  localparam int CTL_TC   = 8;
  localparam int CTL_MERR = 9;
  localparam int CTL_AERR = 10;

  // mode word fields
  localparam int MODE_W    = 6;
  localparam int MODE_IE   = 5;
  localparam logic [1:0] WIDTH_16 = 2'b10;

  // bytes moved by one transfer for a width code
  function automatic logic [1:0] beat_step(input logic [1:0] width);
    return (width == WIDTH_16) ? 2'd2 : 2'd1;
  endfunction

  // true when a transfer of this step empties the count
  function automatic logic drains(input logic [31:0] cnt, input logic [1:0] step);
    return cnt <= {30'd0, step};
  endfunction

  // residual after one transfer, stopping at zero
  function automatic logic [31:0] residual_after(input logic [31:0] cnt,
                                                 input logic [1:0] step);
    return drains(cnt, step) ? 32'd0 : cnt - {30'd0, step};
  endfunction

endpackage

// File: rtl/dmab_decode.sv
module dmab_decode
  import dmab_pkg::*;
#(
  parameter int N_CH = 8,
  localparam int CH_W = $clog2(N_CH),
  localparam int RA_W = CH_W + 5
) (
  input  logic            reg_we,
  input  logic [RA_W-1:0] reg_addr,
  output logic [CH_W-1:0] ch_idx,
  output reg_sel_e        sel,
  output logic            addr_ok,
  output logic [N_CH-1:0] wr_mode,
  output logic [N_CH-1:0] wr_ctrl,
  output logic [N_CH-1:0] wr_cnt,
  output logic [N_CH-1:0] wr_xa
);

  assign ch_idx  = reg_addr[RA_W-1:5];
  assign sel     = reg_sel_e'(reg_addr[4:2]);
  assign addr_ok = (reg_addr[1:0] == 2'b00) && (32'(ch_idx) < N_CH);

  for (genvar g = 0; g < N_CH; g++) begin : g_strobe
    logic hit;
    assign hit        = reg_we && addr_ok && (32'(ch_idx) == g);
    assign wr_mode[g] = hit && (sel == SEL_MODE);
    assign wr_ctrl[g] = hit && (sel == SEL_CTRL);
    assign wr_cnt[g]  = hit && (sel == SEL_COUNT);
    assign wr_xa[g]   = hit && (sel == SEL_XADDR);
  end

endmodule

// File: rtl/dmab_chan.sv
module dmab_chan
  import dmab_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int XA_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] wdata,
  input  logic             wr_mode,
  input  logic             wr_ctrl,
  input  logic             wr_cnt,
  input  logic             wr_xa,
  input  logic             dev_req,
  input  logic             mem_err,
  input  logic             addr_err,
  output logic             dev_ack,
  output logic             dev_dir,
  output logic             irq_req,
  output logic [REG_W-1:0] mode_word,
  output logic [REG_W-1:0] ctrl_word,
  output logic [REG_W-1:0] cnt_word,
  output logic [REG_W-1:0] xa_word
);

  logic [MODE_W-1:0] mode_q;
  logic              en_q, dir_q, tc_q, me_q, ae_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [XA_W-1:0]   xa_q;
  logic              ack_q;
  logic [2:0]        ack_left;
  logic [1:0]        step_q;

  // named internal events
  logic beat_start, beat_done, zero_hit, stop_now;
  logic [31:0] cnt_next;

  assign beat_start = !ack_q && en_q && dev_req;
  assign beat_done  = ack_q && (ack_left == 3'd0);
  assign cnt_next   = residual_after(32'(cnt_q), step_q);
  assign zero_hit   = beat_done && drains(32'(cnt_q), step_q);
  assign stop_now   = zero_hit || mem_err || addr_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      en_q   <= 1'b0;
      dir_q  <= 1'b0;
      tc_q   <= 1'b0;
      me_q   <= 1'b0;
      ae_q   <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= wdata[MODE_W-1:0];
      if (wr_ctrl) dir_q <= wdata[CTL_DIR];
      if (stop_now)     en_q <= 1'b0;
      else if (wr_ctrl) en_q <= wdata[CTL_EN];
      tc_q <= zero_hit || (tc_q && !(wr_ctrl && wdata[CTL_TC]));
      me_q <= mem_err  || (me_q && !(wr_ctrl && wdata[CTL_MERR]));
      ae_q <= addr_err || (ae_q && !(wr_ctrl && wdata[CTL_AERR]));
    end
  end

  // acknowledge sequencer: length latched at the start of each transfer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q    <= 1'b0;
      ack_left <= '0;
      step_q   <= 2'd1;
    end else if (beat_start) begin
      ack_q    <= 1'b1;
      ack_left <= mode_q[2:0];
      step_q   <= beat_step(mode_q[4:3]);
    end else if (beat_done) begin
      ack_q    <= 1'b0;
    end else if (ack_q) begin
      ack_left <= ack_left - 3'd1;
    end
  end

  // finishing transfer has priority over a software write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      xa_q  <= '0;
    end else begin
      if (beat_done)   cnt_q <= cnt_next[CNT_W-1:0];
      else if (wr_cnt) cnt_q <= wdata[CNT_W-1:0];
      if (beat_done)   xa_q  <= xa_q + XA_W'(step_q);
      else if (wr_xa)  xa_q  <= wdata[XA_W-1:0];
    end
  end

  assign dev_ack = ack_q;
  assign dev_dir = dir_q;
  assign irq_req = mode_q[MODE_IE] && (tc_q || me_q || ae_q);

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[CTL_EN]   = en_q;
    ctrl_word[CTL_DIR]  = dir_q;
    ctrl_word[CTL_TC]   = tc_q;
    ctrl_word[CTL_MERR] = me_q;
    ctrl_word[CTL_AERR] = ae_q;
  end
  assign mode_word = REG_W'(mode_q);
  assign cnt_word  = REG_W'(cnt_q);
  assign xa_word   = REG_W'(xa_q);

  // R4
  ack_start_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(en_q) && $past(dev_req));

  // R5
  count_only_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && !beat_done) |=> $stable(cnt_q));

  // R6
  tc_stops_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_q) |-> !en_q);

  // R7
  err_stops_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_err || addr_err) |=> !en_q && (me_q || ae_q));

  // R9
  ack_runs_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && ack_left != 3'd0) |=> ack_q);

endmodule

// File: rtl/dmab_bank.sv
module dmab_bank
  import dmab_pkg::*;
#(
  parameter int N_CH  = 8,
  parameter int CNT_W = 24,
  parameter int XA_W  = 32,
  localparam int CH_W = $clog2(N_CH),
  localparam int RA_W = CH_W + 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [N_CH-1:0]  dev_req,
  output logic [N_CH-1:0]  dev_ack,
  output logic [N_CH-1:0]  dev_dir,
  input  logic [N_CH-1:0]  mem_err,
  input  logic [N_CH-1:0]  addr_err,
  output logic             irq
);

  logic [CH_W-1:0] ch_idx;
  reg_sel_e        sel;
  logic            addr_ok;
  logic [N_CH-1:0] wr_mode, wr_ctrl, wr_cnt, wr_xa, irq_vec;
  logic [REG_W-1:0] mode_w [N_CH];
  logic [REG_W-1:0] ctrl_w [N_CH];
  logic [REG_W-1:0] cnt_w  [N_CH];
  logic [REG_W-1:0] xa_w   [N_CH];

  dmab_decode #(.N_CH(N_CH)) u_decode (
    .reg_we  (reg_we),
    .reg_addr(reg_addr),
    .ch_idx  (ch_idx),
    .sel     (sel),
    .addr_ok (addr_ok),
    .wr_mode (wr_mode),
    .wr_ctrl (wr_ctrl),
    .wr_cnt  (wr_cnt),
    .wr_xa   (wr_xa)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_chan
    dmab_chan #(.CNT_W(CNT_W), .XA_W(XA_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wdata    (reg_wdata),
      .wr_mode  (wr_mode[g]),
      .wr_ctrl  (wr_ctrl[g]),
      .wr_cnt   (wr_cnt[g]),
      .wr_xa    (wr_xa[g]),
      .dev_req  (dev_req[g]),
      .mem_err  (mem_err[g]),
      .addr_err (addr_err[g]),
      .dev_ack  (dev_ack[g]),
      .dev_dir  (dev_dir[g]),
      .irq_req  (irq_vec[g]),
      .mode_word(mode_w[g]),
      .ctrl_word(ctrl_w[g]),
      .cnt_word (cnt_w[g]),
      .xa_word  (xa_w[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (addr_ok) begin
      unique case (sel)
        SEL_MODE:  reg_rdata = mode_w[ch_idx];
        SEL_CTRL:  reg_rdata = ctrl_w[ch_idx];
        SEL_COUNT: reg_rdata = cnt_w[ch_idx];
        SEL_XADDR: reg_rdata = xa_w[ch_idx];
        default:   reg_rdata = '0;
      endcase
    end
  end

  assign irq = |irq_vec;

  // R1
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |-> (wr_mode == '0) && (wr_ctrl == '0) && (wr_cnt == '0) && (wr_xa == '0));

endmodule

// File: tb/dmab_bank_tb.sv
`timescale 1ns/1ps
module dmab_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [7:0]  dev_req, dev_ack, dev_dir, mem_err, addr_err;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dmab_bank dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_req(dev_req),
    .dev_ack(dev_ack), .dev_dir(dev_dir), .mem_err(mem_err),
    .addr_err(addr_err), .irq(irq)
  );

  // {addr, write data, expected read}
  localparam int NV = 6;
  localparam logic [71:0] VEC [NV] = '{
    {8'h60, 32'hFFFF_FFFF, 32'h0000_003F},  // R2 ch3 mode
    {8'hA4, 32'h0000_0703, 32'h0000_0003},  // R3 ch5 control, flags write-1 only clear
    {8'hE8, 32'h0123_4567, 32'h0023_4567},  // R12 ch7 count
    {8'h0C, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R1 ch0 address
    {8'h50, 32'h1234_5678, 32'h0000_0000},  // R1 ch2 reserved kind
    {8'hCC, 32'h0000_0ABC, 32'h0000_0ABC}   // R1 ch6 address
  };

  function automatic logic [7:0] ra(input int ch, input int kind);
    return 8'((ch << 5) | (kind << 2));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a;
    #0.5;
    chk(req, reg_rdata, exp);
  endtask

  task automatic pulse_req(input int ch);
    dev_req[ch] = 1'b1;
    @(negedge clk);
    dev_req[ch] = 1'b0;
  endtask

  task automatic count_ack(input int ch, output int n);
    n = 0;
    for (int k = 0; k < 20; k++) begin
      if (dev_ack[ch]) n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int n;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    dev_req = '0; mem_err = '0; addr_err = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    rd_chk("R11 mode", ra(3, 0), 32'h0);
    rd_chk("R11 ctrl", ra(5, 1), 32'h0);
    rd_chk("R11 count", ra(7, 2), 32'h0);
    chk("R11 ack", 32'(dev_ack), 32'h0);
    chk("R11 irq", 32'(irq), 32'h0);

    // table walk: write then read back
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd_chk("R1 table", VEC[i][71:64], VEC[i][31:0]);
    end
    // second pass: no crosstalk between windows
    for (int i = 0; i < NV; i++) rd_chk("R1 reread", VEC[i][71:64], VEC[i][31:0]);
    rd_chk("R1 ch2 mode untouched", ra(2, 0), 32'h0);
    wr(8'h25, 32'hFFFF_FFFF);   // misaligned: ignored
    rd_chk("R1 misaligned write", ra(1, 1), 32'h0);
    chk("R3 dir ch5", 32'(dev_dir[5]), 32'h1);

    // ch1: 16-bit, access code 2
    wr(ra(1, 0), 32'h12);
    wr(ra(1, 3), 32'h1000);
    wr(ra(1, 2), 32'd6);
    wr(ra(1, 1), 32'h3);
    chk("R3 dir ch1", 32'(dev_dir[1]), 32'h1);
    pulse_req(1);
    count_ack(1, n);
    chk("R4 ack length", 32'(n), 32'd3);
    rd_chk("R5 address step 2", ra(1, 3), 32'h1002);
    rd_chk("R12 residual", ra(1, 2), 32'd4);

    dev_req[1] = 1'b1;
    repeat (20) @(negedge clk);
    dev_req[1] = 1'b0;
    rd_chk("R6 tc set enable off", ra(1, 1), 32'h102);
    rd_chk("R6 count zero", ra(1, 2), 32'd0);
    rd_chk("R5 address end", ra(1, 3), 32'h1006);
    chk("R10 irq masked", 32'(irq), 32'h0);
    wr(ra(1, 0), 32'h32);
    chk("R10 irq enabled", 32'(irq), 32'h1);
    wr(ra(1, 1), 32'h102);
    rd_chk("R8 tc cleared", ra(1, 1), 32'h002);
    chk("R10 irq drops", 32'(irq), 32'h0);

    // R6 saturation: count 1 with 2-byte step
    wr(ra(1, 2), 32'd1);
    wr(ra(1, 1), 32'h3);
    pulse_req(1);
    repeat (10) @(negedge clk);
    rd_chk("R6 saturate count", ra(1, 2), 32'd0);
    rd_chk("R6 saturate tc", ra(1, 1), 32'h102);
    wr(ra(1, 1), 32'h100);
    rd_chk("R8 clear again", ra(1, 1), 32'h0);

    // ch2: 8-bit, access code 0
    wr(ra(2, 0), 32'h08);
    wr(ra(2, 3), 32'h20);
    wr(ra(2, 2), 32'd3);
    wr(ra(2, 1), 32'h1);
    pulse_req(2);
    count_ack(2, n);
    chk("R2 single-cycle ack", 32'(n), 32'd1);
    rd_chk("R2 address step 1", ra(2, 3), 32'h21);
    rd_chk("R2 count step 1", ra(2, 2), 32'd2);
    chk("R3 dir read", 32'(dev_dir[2]), 32'h0);

    // ch0 disabled: request ignored
    wr(ra(0, 2), 32'd5);
    pulse_req(0);
    count_ack(0, n);
    chk("R4 disabled no ack", 32'(n), 32'd0);
    rd_chk("R4 disabled count kept", ra(0, 2), 32'd5);

    // ch4: disable during a long acknowledge
    wr(ra(4, 0), 32'h0F);
    wr(ra(4, 2), 32'd10);
    wr(ra(4, 1), 32'h1);
    pulse_req(4);
    n = dev_ack[4] ? 1 : 0;
    wr(ra(4, 1), 32'h0);
    if (dev_ack[4]) n++;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (dev_ack[4]) n++;
    end
    chk("R9 ack completes", 32'(n), 32'd8);
    rd_chk("R9 count updated", ra(4, 2), 32'd9);
    dev_req[4] = 1'b1;
    count_ack(4, n);
    dev_req[4] = 1'b0;
    chk("R9 no new ack", 32'(n), 32'd0);

    // ch6 errors
    wr(ra(6, 1), 32'h1);
    mem_err[6] = 1'b1; @(negedge clk); mem_err[6] = 1'b0;
    rd_chk("R7 mem error", ra(6, 1), 32'h200);
    addr_err[6] = 1'b1; @(negedge clk); addr_err[6] = 1'b0;
    rd_chk("R7 addr error", ra(6, 1), 32'h600);
    chk("R10 masked errors", 32'(irq), 32'h0);
    wr(ra(6, 0), 32'h20);
    chk("R10 error irq", 32'(irq), 32'h1);
    addr_err[6] = 1'b1;
    wr(ra(6, 1), 32'h600);
    addr_err[6] = 1'b0;
    rd_chk("R8 set beats clear", ra(6, 1), 32'h400);
    wr(ra(6, 1), 32'h000);
    rd_chk("R8 zero write keeps", ra(6, 1), 32'h400);
    wr(ra(6, 1), 32'h400);
    rd_chk("R8 final clear", ra(6, 1), 32'h0);
    chk("R10 irq idle", 32'(irq), 32'h0);

    finish_run();
  end

endmodule